// File: doc/BRIEF.md
# Serial Port Modem-Control Flow Gate

This block sits beside an asynchronous serial transmitter and receiver and decides, cycle by cycle, whether the transmitter may start a character. It also drives the two local handshake lines, picks where the transmit and receive bit ticks come from, and drives two outgoing timing clocks toward the remote equipment. A flow register and a clock register configure it. The flow register picks which handshake lines take part in flow control. The clock register routes the incoming timing strobes and the local baud generator strobes.

The receive side raises an internal stop condition when the receive FIFO level reaches a high watermark, and clears it at a low watermark. That condition lowers the chosen input handshake line and, in isochronous mode, silences the outgoing timing clocks so that the remote end stops clocking data out. The transmit side holds off new characters while the chosen output handshake line is low. It only changes its decision between characters.

A configuration write uses one of three update modes. It can take effect at once. It can wait until the transmit queue has drained. Or it can wait for the drain, pulse a request to discard queued input, and only then take effect. The serializer, the FIFOs and the baud-rate dividers are outside the block and appear only as ports.

Top module: `sio_flowgate`

## Requirements
- R1: After reset the applied flow and clock settings are all zero, tx_permit is 1, rx_flush is 0, both outgoing timing clocks are 0, and both tick outputs follow their own baud generator strobes.
- R2: An internal stop condition sets on the clock edge where rx_level >= HI_MARK and clears on the edge where rx_level <= LO_MARK; between the two it holds. With flow bit 0 set, rts_o is low exactly while the stop condition is set.
- R3: With flow bit 2 set and flow bit 0 clear, dtr_o is low exactly while the stop condition is set, and rts_o stays high. If bits 0 and 2 are both set, only rts_o takes part and dtr_o stays high.
- R4: While port_open is 0, rts_o and dtr_o are both 0. While port_open is 1, each is 1 unless R2 or R3 lowers it.
- R5: With flow bit 1 set, tx_permit becomes 0 on the first edge with tx_busy low and cts_i low, and returns to 1 on the first edge with tx_busy low and cts_i high.
- R6: With flow bit 3 set and flow bit 1 clear, cd_i gates tx_permit in the same way. When bit 1 is also set, cd_i is ignored.
- R7: While tx_busy is high, tx_permit keeps its value. It is updated only on edges where tx_busy is low.
- R8: Clock bits [2:0] select tx_tick and bits [5:3] select rx_tick. Code 1 selects dce_txc_stb and code 2 selects dce_rxc_stb. Code 0 and codes 3 to 7 select the block's own baud strobe: brg_tx_stb for tx_tick, brg_rx_stb for rx_tick.
- R9: Clock bits [8:6] drive dte_txc_o and bits [11:9] drive dte_rxc_o. The codes are 1 = brg_rx_stb, 2 = brg_tx_stb, 3 = dce_txc_stb and 4 = dce_rxc_stb. Code 0 and codes 5 to 7 drive 0.
- R10: With flow bit 4 set, both outgoing timing clocks are 0 while the stop condition is set. With no outgoing source selected, bit 4 changes nothing.
- R11: Update mode 0 (and reserved mode 3) applies the written settings on the clock edge that samples cfg_wr.
- R12: Update mode 1 stores the settings and applies them on the first later edge where tx_empty is 1 and tx_busy is 0. Until then, the previous settings stay in force.
- R13: Update mode 2 waits for the same drained condition, then raises rx_flush for exactly one cycle, and applies the settings on the edge that ends that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_mode | input | 2 | Update mode for this write: 0 at once, 1 after drain, 2 after drain and input flush |
| cfg_flow | input | CFG_W | Flow settings written |
| cfg_clk | input | CFG_W | Clock routing settings written |
| port_open | input | 1 | Port is open; allows the handshake outputs to be asserted |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_busy | input | 1 | A character is being shifted out |
| cts_i | input | 1 | Synchronized clear-to-send level |
| cd_i | input | 1 | Synchronized carrier-detect level |
| dce_txc_stb | input | 1 | Strobe from the remote transmit timing line |
| dce_rxc_stb | input | 1 | Strobe from the remote receive timing line |
| brg_tx_stb | input | 1 | Local transmit baud generator strobe |
| brg_rx_stb | input | 1 | Local receive baud generator strobe |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| tx_permit | output | 1 | Transmitter may start the next character |
| tx_tick | output | 1 | Selected transmit bit tick |
| rx_tick | output | 1 | Selected receive bit tick |
| dte_txc_o | output | 1 | Outgoing transmit timing clock |
| dte_rxc_o | output | 1 | Outgoing receive timing clock |
| rx_flush | output | 1 | One-cycle request to discard queued input |

## Verification
The checker tests these rules on every cycle. A closed port keeps both handshake lines low. tx_permit holds while a character is in flight and drops after a blocked clear-to-send edge. A high FIFO level sets the stop condition, and the stop condition silences the outgoing clocks in isochronous mode. An outgoing clock pulse always has a source strobe behind it. The flush request lasts one cycle and only follows a drained queue. The bench alone covers the remaining behaviour. That includes the hysteresis between the two watermarks and the routing of every clock code, reserved codes included. It also covers which handshake line wins when both are enabled, that staged settings stay out of force while the queue holds data, and that the settings change exactly on the edge after the flush pulse.

// File: rtl/sio_flowgate_pkg.sv
package sio_flowgate_pkg;

  // Positions of the flow enables inside the flow register
  localparam int unsigned FL_RTS = 0;
  localparam int unsigned FL_CTS = 1;
  localparam int unsigned FL_DTR = 2;
  localparam int unsigned FL_CD  = 3;
  localparam int unsigned FL_ISO = 4;
  localparam int unsigned FL_USED = 5;

  // Clock register: four 3-bit select fields from bit 0 upward
  localparam int unsigned CK_FLD_W = 3;
  localparam int unsigned CK_USED  = 4 * CK_FLD_W;

  typedef enum logic [1:0] {
    UPD_NOW   = 2'd0,
    UPD_DRAIN = 2'd1,
    UPD_FLUSH = 2'd2,
    UPD_RSVD  = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FLUSH = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    IN_OWN_BRG = 2'd0,
    IN_DCE_TX  = 2'd1,
    IN_DCE_RX  = 2'd2
  } in_src_e;

  typedef enum logic [2:0] {
    OUT_OFF    = 3'd0,
    OUT_BRG_RX = 3'd1,
    OUT_BRG_TX = 3'd2,
    OUT_DCE_TX = 3'd3,
    OUT_DCE_RX = 3'd4
  } out_src_e;

  typedef struct packed {
    logic rts_fc;
    logic dtr_fc;
    logic cts_fc;
    logic cd_fc;
    logic iso_fc;
  } flow_sel_t;

  // Reserved codes fall back to the local generator
  function automatic in_src_e decode_in(input logic [CK_FLD_W-1:0] code);
    case (code)
      3'd1:    return IN_DCE_TX;
      3'd2:    return IN_DCE_RX;
      default: return IN_OWN_BRG;
    endcase
  endfunction

  // Reserved codes leave the output quiet
  function automatic out_src_e decode_out(input logic [CK_FLD_W-1:0] code);
    case (code)
      3'd1:    return OUT_BRG_RX;
      3'd2:    return OUT_BRG_TX;
      3'd3:    return OUT_DCE_TX;
      3'd4:    return OUT_DCE_RX;
      default: return OUT_OFF;
    endcase
  endfunction

  // RTS wins over DTR, CTS wins over CD when both are enabled
  function automatic flow_sel_t decode_flow(input logic [FL_USED-1:0] f);
    flow_sel_t s;
    s.rts_fc = f[FL_RTS];
    s.dtr_fc = f[FL_DTR] & ~f[FL_RTS];
    s.cts_fc = f[FL_CTS];
    s.cd_fc  = f[FL_CD] & ~f[FL_CTS];
    s.iso_fc = f[FL_ISO];
    return s;
  endfunction

  function automatic logic pick_in(input in_src_e s, input logic own,
                                   input logic dtx, input logic drx);
    case (s)
      IN_DCE_TX: return dtx;
      IN_DCE_RX: return drx;
      default:   return own;
    endcase
  endfunction

  function automatic logic pick_out(input out_src_e s, input logic brx, input logic btx,
                                    input logic dtx, input logic drx);
    case (s)
      OUT_BRG_RX: return brx;
      OUT_BRG_TX: return btx;
      OUT_DCE_TX: return dtx;
      OUT_DCE_RX: return drx;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_stage.sv
module sio_cfg_stage import sio_flowgate_pkg::*; #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic [CFG_W-1:0] cfg_flow,
  input  logic [CFG_W-1:0] cfg_clk,
  input  logic             drained,
  output logic [CFG_W-1:0] act_flow,
  output logic [CFG_W-1:0] act_clk,
  output logic             rx_flush
);

  stage_e           st;
  logic [CFG_W-1:0] pend_flow;
  logic [CFG_W-1:0] pend_clk;
  logic             pend_flush;
  upd_mode_e        wmode;

  assign wmode = upd_mode_e'(cfg_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      act_flow   <= '0;
      act_clk    <= '0;
      pend_flow  <= '0;
      pend_clk   <= '0;
      pend_flush <= 1'b0;
      rx_flush   <= 1'b0;
    end else begin
      rx_flush <= 1'b0;
      if (cfg_wr) begin
        if (wmode == UPD_DRAIN || wmode == UPD_FLUSH) begin
          pend_flow  <= cfg_flow;
          pend_clk   <= cfg_clk;
          pend_flush <= (wmode == UPD_FLUSH);
          st         <= ST_WAIT;
        end else begin
          act_flow <= cfg_flow;
          act_clk  <= cfg_clk;
          st       <= ST_IDLE;
        end
      end else begin
        case (st)
          ST_WAIT: begin
            if (drained) begin
              if (pend_flush) begin
                rx_flush <= 1'b1;
                st       <= ST_FLUSH;
              end else begin
                act_flow <= pend_flow;
                act_clk  <= pend_clk;
                st       <= ST_IDLE;
              end
            end
          end
          ST_FLUSH: begin
            act_flow <= pend_flow;
            act_clk  <= pend_clk;
            st       <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_rx_watch.sv
module sio_rx_watch #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned HI_MARK = 12,
  parameter int unsigned LO_MARK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_stop
);

  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO_MARK);

  logic at_hi;
  logic at_lo;

  assign at_hi = (rx_level >= HI_L);
  assign at_lo = (rx_level <= LO_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_stop <= 1'b0;
    else if (at_hi) rx_stop <= 1'b1;
    else if (at_lo) rx_stop <= 1'b0;
  end

endmodule

// File: rtl/sio_hs_ctl.sv
module sio_hs_ctl import sio_flowgate_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  flow_sel_t fsel,
  input  logic      port_open,
  input  logic      rx_stop,
  input  logic      cts_i,
  input  logic      cd_i,
  input  logic      tx_busy,
  output logic      rts_o,
  output logic      dtr_o,
  output logic      tx_permit,
  output logic      gate_ok
);

  assign rts_o   = port_open & ~(fsel.rts_fc & rx_stop);
  assign dtr_o   = port_open & ~(fsel.dtr_fc & rx_stop);
  assign gate_ok = ~(fsel.cts_fc & ~cts_i) & ~(fsel.cd_fc & ~cd_i);

  // The decision only moves between characters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_permit <= 1'b1;
    else if (!tx_busy) tx_permit <= gate_ok;
  end

endmodule

// File: rtl/sio_clk_route.sv
module sio_clk_route import sio_flowgate_pkg::*; (
  input  logic               clk,
  input  logic [CK_USED-1:0] clk_cfg,
  input  logic               brg_tx_stb,
  input  logic               brg_rx_stb,
  input  logic               dce_txc_stb,
  input  logic               dce_rxc_stb,
  input  logic               iso_block,
  output logic               tx_tick,
  output logic               rx_tick,
  output logic               dte_txc_o,
  output logic               dte_rxc_o
);

  logic [1:0] in_tick;
  logic [1:0] out_tick;

  // Field 0 feeds the transmit tick, field 1 the receive tick
  for (genvar g = 0; g < 2; g++) begin : g_in
    in_src_e sel;
    logic    own;
    assign sel        = decode_in(clk_cfg[g*CK_FLD_W +: CK_FLD_W]);
    assign own        = (g == 0) ? brg_tx_stb : brg_rx_stb;
    assign in_tick[g] = pick_in(sel, own, dce_txc_stb, dce_rxc_stb);
  end

  // Fields 2 and 3 feed the two outgoing timing lines
  for (genvar g = 0; g < 2; g++) begin : g_out
    out_src_e sel;
    assign sel         = decode_out(clk_cfg[(g+2)*CK_FLD_W +: CK_FLD_W]);
    assign out_tick[g] = ~iso_block &
                         pick_out(sel, brg_rx_stb, brg_tx_stb, dce_txc_stb, dce_rxc_stb);
  end

  assign tx_tick   = in_tick[0];
  assign rx_tick   = in_tick[1];
  assign dte_txc_o = out_tick[0];
  assign dte_rxc_o = out_tick[1];

  logic unused_clk;
  assign unused_clk = clk;

endmodule

// File: rtl/sio_flowgate.sv
module sio_flowgate import sio_flowgate_pkg::*; #(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned HI_MARK = 12,
  parameter int unsigned LO_MARK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic [CFG_W-1:0] cfg_flow,
  input  logic [CFG_W-1:0] cfg_clk,
  input  logic             port_open,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_empty,
  input  logic             tx_busy,
  input  logic             cts_i,
  input  logic             cd_i,
  input  logic             dce_txc_stb,
  input  logic             dce_rxc_stb,
  input  logic             brg_tx_stb,
  input  logic             brg_rx_stb,
  output logic             rts_o,
  output logic             dtr_o,
  output logic             tx_permit,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             dte_txc_o,
  output logic             dte_rxc_o,
  output logic             rx_flush
);

  logic [CFG_W-1:0] act_flow;
  logic [CFG_W-1:0] act_clk;
  flow_sel_t        fsel;
  logic             drained;
  logic             rx_stop;
  logic             iso_block;
  logic             cts_gate_en;
  logic             gate_ok;

  assign drained     = tx_empty & ~tx_busy;
  assign fsel        = decode_flow(act_flow[FL_USED-1:0]);
  assign iso_block   = fsel.iso_fc & rx_stop;
  assign cts_gate_en = fsel.cts_fc;

  sio_cfg_stage #(.CFG_W(CFG_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_mode (cfg_mode),
    .cfg_flow (cfg_flow),
    .cfg_clk  (cfg_clk),
    .drained  (drained),
    .act_flow (act_flow),
    .act_clk  (act_clk),
    .rx_flush (rx_flush)
  );

  sio_rx_watch #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_level (rx_level),
    .rx_stop  (rx_stop)
  );

  sio_hs_ctl u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsel      (fsel),
    .port_open (port_open),
    .rx_stop   (rx_stop),
    .cts_i     (cts_i),
    .cd_i      (cd_i),
    .tx_busy   (tx_busy),
    .rts_o     (rts_o),
    .dtr_o     (dtr_o),
    .tx_permit (tx_permit),
    .gate_ok   (gate_ok)
  );

  sio_clk_route u_route (
    .clk         (clk),
    .clk_cfg     (act_clk[CK_USED-1:0]),
    .brg_tx_stb  (brg_tx_stb),
    .brg_rx_stb  (brg_rx_stb),
    .dce_txc_stb (dce_txc_stb),
    .dce_rxc_stb (dce_rxc_stb),
    .iso_block   (iso_block),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick),
    .dte_txc_o   (dte_txc_o),
    .dte_rxc_o   (dte_rxc_o)
  );

  logic unused_bits;
  assign unused_bits = ^{act_flow[CFG_W-1:FL_USED], act_clk[CFG_W-1:CK_USED], gate_ok};

endmodule

// File: rtl/sio_flowgate_chk.sv
module sio_flowgate_chk #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned HI_MARK = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_open,
  input logic             rts_o,
  input logic             dtr_o,
  input logic             tx_busy,
  input logic             tx_permit,
  input logic             cts_i,
  input logic             cts_gate_en,
  input logic             rx_flush,
  input logic             drained,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_stop,
  input logic             iso_block,
  input logic             dte_txc_o,
  input logic             dte_rxc_o,
  input logic             brg_tx_stb,
  input logic             brg_rx_stb,
  input logic             dce_txc_stb,
  input logic             dce_rxc_stb
);

  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);

  a_r4_closed_low: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open |-> (!rts_o && !dtr_o));

  a_r7_hold_in_char: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> (tx_permit == $past(tx_permit)));

  a_r5_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cts_gate_en && !cts_i) |=> !tx_permit);

  a_r2_stop_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= HI_L) |=> rx_stop);

  a_r10_iso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    iso_block |-> (!dte_txc_o && !dte_rxc_o));

  a_r9_out_has_src: assert property (@(posedge clk) disable iff (!rst_n)
    (dte_txc_o || dte_rxc_o) |-> (brg_tx_stb || brg_rx_stb || dce_txc_stb || dce_rxc_stb));

  a_r13_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush);

  a_r13_flush_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flush) |-> $past(drained));

endmodule

bind sio_flowgate sio_flowgate_chk #(.LVL_W(LVL_W), .HI_MARK(HI_MARK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_open   (port_open),
  .rts_o       (rts_o),
  .dtr_o       (dtr_o),
  .tx_busy     (tx_busy),
  .tx_permit   (tx_permit),
  .cts_i       (cts_i),
  .cts_gate_en (cts_gate_en),
  .rx_flush    (rx_flush),
  .drained     (drained),
  .rx_level    (rx_level),
  .rx_stop     (rx_stop),
  .iso_block   (iso_block),
  .dte_txc_o   (dte_txc_o),
  .dte_rxc_o   (dte_rxc_o),
  .brg_tx_stb  (brg_tx_stb),
  .brg_rx_stb  (brg_rx_stb),
  .dce_txc_stb (dce_txc_stb),
  .dce_rxc_stb (dce_rxc_stb)
);

// File: tb/sio_flowgate_tb.sv
module sio_flowgate_tb;

  localparam int unsigned CFG_W = 16;
  localparam int unsigned LVL_W = 5;
  localparam int unsigned HI    = 12;
  localparam int unsigned LO    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [1:0]       cfg_mode = '0;
  logic [CFG_W-1:0] cfg_flow = '0;
  logic [CFG_W-1:0] cfg_clk = '0;
  logic             port_open = 1'b1;
  logic [LVL_W-1:0] rx_level = '0;
  logic             tx_empty = 1'b1;
  logic             tx_busy = 1'b0;
  logic             cts_i = 1'b1;
  logic             cd_i = 1'b1;
  logic             dce_txc_stb = 1'b0;
  logic             dce_rxc_stb = 1'b0;
  logic             brg_tx_stb = 1'b0;
  logic             brg_rx_stb = 1'b0;
  logic             rts_o, dtr_o, tx_permit, tx_tick, rx_tick, dte_txc_o, dte_rxc_o, rx_flush;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sio_flowgate #(.CFG_W(CFG_W), .LVL_W(LVL_W), .HI_MARK(HI), .LO_MARK(LO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_flow(cfg_flow),
    .cfg_clk(cfg_clk), .port_open(port_open), .rx_level(rx_level), .tx_empty(tx_empty),
    .tx_busy(tx_busy), .cts_i(cts_i), .cd_i(cd_i), .dce_txc_stb(dce_txc_stb),
    .dce_rxc_stb(dce_rxc_stb), .brg_tx_stb(brg_tx_stb), .brg_rx_stb(brg_rx_stb),
    .rts_o(rts_o), .dtr_o(dtr_o), .tx_permit(tx_permit), .tx_tick(tx_tick),
    .rx_tick(rx_tick), .dte_txc_o(dte_txc_o), .dte_rxc_o(dte_rxc_o), .rx_flush(rx_flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench model of the routing, written from the requirement tables
  function automatic logic m_in(input logic [2:0] code, input logic own,
                                input logic dtx, input logic drx);
    if (code == 3'd1) return dtx;
    if (code == 3'd2) return drx;
    return own;
  endfunction

  function automatic logic m_out(input logic [2:0] code, input logic brx, input logic btx,
                                 input logic dtx, input logic drx);
    logic [3:0] srcs;
    srcs = {drx, dtx, btx, brx};
    if (code >= 3'd1 && code <= 3'd4) return srcs[code - 3'd1];
    return 1'b0;
  endfunction

  function automatic logic m_permit(input logic [15:0] f, input logic cts, input logic cd);
    logic blk;
    blk = (f[1] && !cts) || (f[3] && !f[1] && !cd);
    return !blk;
  endfunction

  task automatic wr_cfg(input logic [1:0] mode, input logic [15:0] f, input logic [15:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = mode; cfg_flow = f; cfg_clk = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic        m_stop;
    logic [15:0] pf;
    logic [15:0] nf;
    logic [15:0] nc;
    int unsigned seed_set;
    seed_set = $urandom(32'd4242);

    step(3);
    rst_n = 1'b1;
    brg_tx_stb = 1'b1; brg_rx_stb = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 rts", rts_o, 1); chk("R1 dtr", dtr_o, 1);
    chk("R1 permit", tx_permit, 1); chk("R1 flush", rx_flush, 0);
    chk("R1 dte_txc", dte_txc_o, 0); chk("R1 dte_rxc", dte_rxc_o, 0);
    chk("R1 tx_tick", tx_tick, 1); chk("R1 rx_tick", rx_tick, 1);
    brg_tx_stb = 1'b0; brg_rx_stb = 1'b0;

    // R4 closed port
    port_open = 1'b0; #1;
    chk("R4 rts closed", rts_o, 0); chk("R4 dtr closed", dtr_o, 0);
    port_open = 1'b1; #1;
    chk("R4 rts open", rts_o, 1);

    // R2 watermark hysteresis on RTS
    wr_cfg(2'd0, 16'h0001, 16'h0000);
    rx_level = 5'd11; step(1); chk("R2 below hi", rts_o, 1);
    rx_level = 5'd12; step(1); chk("R2 at hi", rts_o, 0);
    chk("R3 dtr unaffected", dtr_o, 1);
    rx_level = 5'd8;  step(1); chk("R2 between marks", rts_o, 0);
    rx_level = 5'd4;  step(1); chk("R2 at lo", rts_o, 1);

    // R3 DTR flow, and RTS priority
    wr_cfg(2'd0, 16'h0005, 16'h0000);
    rx_level = 5'd12; step(1);
    chk("R3 both set rts", rts_o, 0); chk("R3 both set dtr", dtr_o, 1);
    wr_cfg(2'd0, 16'h0004, 16'h0000);
    chk("R3 dtr flow", dtr_o, 0); chk("R3 rts held", rts_o, 1);
    rx_level = 5'd0; step(1);
    chk("R3 dtr back", dtr_o, 1);

    // R5 and R7 clear-to-send gating at character boundaries
    wr_cfg(2'd0, 16'h0002, 16'h0000);
    tx_busy = 1'b1; cts_i = 1'b0; step(2);
    chk("R7 held while busy", tx_permit, 1);
    tx_busy = 1'b0; step(1);
    chk("R5 cts low", tx_permit, 0);
    cts_i = 1'b1; step(1);
    chk("R5 cts high", tx_permit, 1);

    // R6 carrier-detect gating and CTS priority
    wr_cfg(2'd0, 16'h0008, 16'h0000);
    cd_i = 1'b0; step(1);
    chk("R6 cd low", tx_permit, 0);
    wr_cfg(2'd0, 16'h000A, 16'h0000);
    step(1);
    chk("R6 cd ignored", tx_permit, 1);
    cd_i = 1'b1;

    // R10 isochronous clock gating
    wr_cfg(2'd0, 16'h0010, 16'h0080);
    brg_tx_stb = 1'b1; #1;
    chk("R10 clock running", dte_txc_o, 1);
    rx_level = 5'd12; step(1);
    chk("R10 clock stopped", dte_txc_o, 0);
    chk("R10 tx tick kept", tx_tick, 1);
    rx_level = 5'd0; step(1);
    chk("R10 clock resumed", dte_txc_o, 1);
    wr_cfg(2'd0, 16'h0011, 16'h0000);
    rx_level = 5'd12; step(1);
    chk("R10 no source rts", rts_o, 0);
    chk("R10 no source quiet", dte_txc_o, 0);
    rx_level = 5'd0; step(1);
    wr_cfg(2'd0, 16'h0000, 16'h0080);

    // R12 staged until drain
    brg_tx_stb = 1'b0; dce_txc_stb = 1'b1;
    tx_empty = 1'b0;
    wr_cfg(2'd1, 16'h0000, 16'h0001);
    step(3);
    chk("R12 not yet applied", tx_tick, 0);
    tx_empty = 1'b1; tx_busy = 1'b1; step(2);
    chk("R12 busy blocks", tx_tick, 0);
    tx_busy = 1'b0; step(1);
    chk("R12 applied", tx_tick, 1);
    chk("R12 no flush", rx_flush, 0);

    // R13 drain, flush pulse, then apply
    brg_rx_stb = 1'b0;
    tx_empty = 1'b0;
    wr_cfg(2'd2, 16'h0000, 16'h0008);
    step(2);
    chk("R13 waiting flush", rx_flush, 0);
    chk("R13 waiting cfg", rx_tick, 0);
    tx_empty = 1'b1; step(1);
    chk("R13 flush pulse", rx_flush, 1);
    chk("R13 cfg not yet", rx_tick, 0);
    step(1);
    chk("R13 flush ends", rx_flush, 0);
    chk("R13 cfg applied", rx_tick, 1);

    // R11 mode 3 acts as immediate
    wr_cfg(2'd3, 16'h0000, 16'h0000);
    chk("R11 reserved mode", rx_tick, 0);

    // Random immediate writes checked against the bench model
    rx_level = 5'd0; step(2);
    m_stop = 1'b0;
    pf = 16'h0000;
    for (int i = 0; i < 300; i++) begin
      nf = 16'($urandom);
      nc = 16'($urandom);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_mode = 2'd0; cfg_flow = nf; cfg_clk = nc;
      rx_level = 5'($urandom_range(0, 16));
      port_open = ($urandom_range(0, 7) != 0);
      cts_i = 1'($urandom); cd_i = 1'($urandom);
      brg_tx_stb = 1'($urandom); brg_rx_stb = 1'($urandom);
      dce_txc_stb = 1'($urandom); dce_rxc_stb = 1'($urandom);
      tx_busy = 1'b0; tx_empty = 1'b1;
      @(negedge clk);
      if (rx_level >= HI) m_stop = 1'b1;
      else if (rx_level <= LO) m_stop = 1'b0;
      chk("R11 R2 rts", rts_o, port_open && !(nf[0] && m_stop));
      chk("R3 R4 dtr", dtr_o, port_open && !(nf[2] && !nf[0] && m_stop));
      chk("R8 tx_tick", tx_tick, m_in(nc[2:0], brg_tx_stb, dce_txc_stb, dce_rxc_stb));
      chk("R8 rx_tick", rx_tick, m_in(nc[5:3], brg_rx_stb, dce_txc_stb, dce_rxc_stb));
      chk("R9 R10 dte_txc", dte_txc_o, !(nf[4] && m_stop) &&
          m_out(nc[8:6], brg_rx_stb, brg_tx_stb, dce_txc_stb, dce_rxc_stb));
      chk("R9 R10 dte_rxc", dte_rxc_o, !(nf[4] && m_stop) &&
          m_out(nc[11:9], brg_rx_stb, brg_tx_stb, dce_txc_stb, dce_rxc_stb));
      chk("R5 R6 permit", tx_permit, m_permit(pf, cts_i, cd_i));
      pf = nf;
    end
    cfg_wr = 1'b0;
    step(2);
    finish_run();
  end

endmodule